// File: doc/BRIEF.md
# Flash Program/Erase Status Controller

This block is the command and status engine of a NOR-style flash array. It accepts one command per cycle: word program, block erase, blank check, suspend, resume and clear status. Program and erase run as a loop of pulses. Each pulse takes one clock cycle, and the array's verify result for that pulse arrives on an input port. The operation ends either on the first passing verify or when a pulse budget is used up. A blank check reads one word of the block per cycle from an input port. It stops at the first word that is not all ones.

An 8-bit status byte and a busy flag report the state of the controller. Error flags are sticky: once set, they hold until a clear-status command or a reset, and while set they refuse any new operation of the matching kind. The supply-valid input is sampled only when a program or erase is launched. A suspend request takes effect only after a fixed latency, so an operation that finishes inside that window completes normally and leaves no suspend flag behind.

Top module: `flash_status_ctl`

## Requirements
- R1: After reset the status byte reads 8'h80 and busy is 0.
- R2: Status bit 7 (ready) is 0 while an operation runs (busy=1) and 1 otherwise. Command codes on cmdCode are: 1 program, 2 erase, 3 blank check, 4 suspend, 5 resume, 6 clear status, and 0 or 7 no operation.
- R3: An accepted program or erase makes the controller busy from the next cycle. It then applies one pulse per cycle and returns to ready on the first pulse whose verifyPass is 1.
- R4: If verifyPass is 0 on all MAX_PULSES pulses of an erase, status bit 5 is set and the controller returns to ready.
- R5: A blank check scans BLOCK_WORDS words, one per cycle. It sets status bit 5 and ends on the first readWord that differs from 16'hFFFF. Otherwise it ends clean after BLOCK_WORDS cycles.
- R6: supplyOk is sampled only when a program or erase is issued. If it is 0 then, status bit 3 is set and no operation starts. A drop of supplyOk during an operation has no effect.
- R7: Bits 5, 4 and 3 stay set until a clear-status command, which clears all three while the controller is ready.
- R8: A program is refused while bit 4 or bit 3 is set. An erase is refused while bit 5 or bit 3 is set. A blank check is refused while bit 5 is set. A refused command leaves the status unchanged and busy at 0.
- R9: A suspend accepted during a program or erase pauses it exactly SUSP_LATENCY cycles later. On that cycle ready goes to 1 and bit 6 (erase) or bit 2 (program) is set.
- R10: If the operation completes within the suspend latency, it finishes normally and no suspend bit is set.
- R11: A resume while paused clears the suspend bit and makes the controller busy again. The pulse count reached before the pause is kept.
- R12: While busy, every command except suspend is ignored. Suspend is ignored when idle, when paused, during a blank check, or while a suspend is already pending. Resume is ignored unless paused. While paused, only resume and clear status act.
- R13: Bits 6 and 2 read 0 whenever ready is 0.
- R14: If MAX_PULSES pulses of a program all fail verify, status bit 4 is set and the controller returns to ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdCode | input | 3 | Command code |
| supplyOk | input | 1 | Programming supply valid, sampled at program/erase issue |
| verifyPass | input | 1 | Verify result of the pulse applied this cycle |
| readWord | input | 16 | Array word returned for the current blank-check address |
| status | output | 8 | Status byte |
| busy | output | 1 | Operation in progress |

## Verification
The assertions assume that cmdValid, cmdCode, supplyOk, verifyPass and readWord are stable and known around each rising edge. They also assume that verifyPass and readWord carry meaning only on cycles in which a pulse or a word read happens. The bench changes all inputs only on falling edges. It holds verifyPass and readWord at fixed values except where a scenario deliberately flips them between two pulses, for example to make an operation complete inside the suspend window. Command strobes last exactly one cycle, so no command is counted twice.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_PROGRAM = 3'd1,
    CMD_ERASE   = 3'd2,
    CMD_BLANK   = 3'd3,
    CMD_SUSPEND = 3'd4,
    CMD_RESUME  = 3'd5,
    CMD_CLEAR   = 3'd6,
    CMD_NOP7    = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUSY   = 2'd1,
    ST_PAUSED = 2'd2
  } state_e;

  typedef enum logic [1:0] {
    OP_PROGRAM = 2'd0,
    OP_ERASE   = 2'd1,
    OP_BLANK   = 2'd2
  } op_e;

  typedef struct packed {
    logic startOp;
    logic pulseStep;
    logic wordStep;
    logic loadLat;
    logic stepLat;
    logic dropPending;
    logic setEraseErr;
    logic setProgErr;
    logic setSupplyErr;
    logic clearErr;
    logic setSuspErase;
    logic setSuspProg;
    logic clearSusp;
  } strobe_t;

  localparam int STAT_READY     = 7;
  localparam int STAT_SUSP_ERS  = 6;
  localparam int STAT_ERASE_ERR = 5;
  localparam int STAT_PROG_ERR  = 4;
  localparam int STAT_SUPPLY    = 3;
  localparam int STAT_SUSP_PRG  = 2;

endpackage

// File: rtl/flash_ctl_datapath.sv
module flash_ctl_datapath
  import flash_ctl_pkg::*;
#(
  parameter int MAX_PULSES   = 8,
  parameter int SUSP_LATENCY = 4,
  parameter int BLOCK_WORDS  = 16,
  parameter int WORD_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] readWord,
  output logic              wordBlank,
  output logic              pulseLast,
  output logic              wordLast,
  output logic              latZero,
  output logic              pending,
  output logic              errErase,
  output logic              errProg,
  output logic              errSupply,
  output logic              suspErase,
  output logic              suspProg
);

  localparam int PCNT_W = (MAX_PULSES > 1) ? $clog2(MAX_PULSES) : 1;
  localparam int LAT_W  = (SUSP_LATENCY > 1) ? $clog2(SUSP_LATENCY) : 1;
  localparam int WCNT_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;
  localparam logic [PCNT_W-1:0] PULSE_TOP = PCNT_W'(MAX_PULSES - 1);
  localparam logic [LAT_W-1:0]  LAT_TOP   = LAT_W'(SUSP_LATENCY - 1);
  localparam logic [WCNT_W-1:0] WORD_TOP  = WCNT_W'(BLOCK_WORDS - 1);

  logic [PCNT_W-1:0] pulseCnt;
  logic [LAT_W-1:0]  latCnt;
  logic [WCNT_W-1:0] wordCnt;

  assign wordBlank = (readWord == {WORD_W{1'b1}});
  assign pulseLast = (pulseCnt == PULSE_TOP);
  assign wordLast  = (wordCnt == WORD_TOP);
  assign latZero   = (latCnt == '0);

  // Operation progress counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
      wordCnt  <= '0;
    end else if (stb.startOp) begin
      pulseCnt <= '0;
      wordCnt  <= '0;
    end else begin
      if (stb.pulseStep) pulseCnt <= pulseCnt + PCNT_W'(1);
      if (stb.wordStep)  wordCnt  <= wordCnt + WCNT_W'(1);
    end
  end

  // Suspend latency window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      latCnt  <= '0;
    end else begin
      if (stb.dropPending)  pending <= 1'b0;
      else if (stb.loadLat) pending <= 1'b1;
      if (stb.loadLat)      latCnt <= LAT_TOP;
      else if (stb.stepLat) latCnt <= latCnt - LAT_W'(1);
    end
  end

  // Sticky error flags and suspend flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errErase  <= 1'b0;
      errProg   <= 1'b0;
      errSupply <= 1'b0;
      suspErase <= 1'b0;
      suspProg  <= 1'b0;
    end else begin
      if (stb.clearErr) begin
        errErase  <= 1'b0;
        errProg   <= 1'b0;
        errSupply <= 1'b0;
      end else begin
        errErase  <= errErase  | stb.setEraseErr;
        errProg   <= errProg   | stb.setProgErr;
        errSupply <= errSupply | stb.setSupplyErr;
      end
      if (stb.clearSusp) begin
        suspErase <= 1'b0;
        suspProg  <= 1'b0;
      end else begin
        suspErase <= suspErase | stb.setSuspErase;
        suspProg  <= suspProg  | stb.setSuspProg;
      end
    end
  end

  // R14: the pulse counter never steps past the final pulse
  a_r14_pulse_bound: assert property (@(posedge clk) disable iff (!rstN)
    stb.pulseStep |-> !pulseLast);

  // R7: error flags persist unless cleared
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errErase || errProg || errSupply) && !stb.clearErr
      |=> (errErase || errProg || errSupply));

  // R9: the latency window only counts down while not yet expired
  a_r9_latency_step: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepLat |-> (pending && !latZero));

endmodule

// File: rtl/flash_ctl_control.sv
module flash_ctl_control
  import flash_ctl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  cmd_e    cmd,
  input  logic    supplyOk,
  input  logic    verifyPass,
  input  logic    wordBlank,
  input  logic    pulseLast,
  input  logic    wordLast,
  input  logic    latZero,
  input  logic    pending,
  input  logic    errErase,
  input  logic    errProg,
  input  logic    errSupply,
  input  logic    suspErase,
  input  logic    suspProg,
  output strobe_t stb,
  output logic    busy
);

  state_e state, stateNext;
  op_e    opKind, opNext;
  logic   finishOp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opKind <= OP_PROGRAM;
    end else begin
      state  <= stateNext;
      opKind <= opNext;
    end
  end

  assign busy = (state == ST_BUSY);

  always_comb begin
    stb       = '0;
    stateNext = state;
    opNext    = opKind;
    finishOp  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          case (cmd)
            CMD_PROGRAM: begin
              if (!(errProg || errSupply)) begin
                if (!supplyOk) begin
                  stb.setSupplyErr = 1'b1;
                end else begin
                  stb.startOp = 1'b1;
                  opNext      = OP_PROGRAM;
                  stateNext   = ST_BUSY;
                end
              end
            end
            CMD_ERASE: begin
              if (!(errErase || errSupply)) begin
                if (!supplyOk) begin
                  stb.setSupplyErr = 1'b1;
                end else begin
                  stb.startOp = 1'b1;
                  opNext      = OP_ERASE;
                  stateNext   = ST_BUSY;
                end
              end
            end
            CMD_BLANK: begin
              if (!errErase) begin
                stb.startOp = 1'b1;
                opNext      = OP_BLANK;
                stateNext   = ST_BUSY;
              end
            end
            CMD_CLEAR: stb.clearErr = 1'b1;
            default: ;
          endcase
        end
      end
      ST_PAUSED: begin
        if (cmdValid) begin
          if (cmd == CMD_RESUME) begin
            stb.clearSusp = 1'b1;
            stateNext     = ST_BUSY;
          end else if (cmd == CMD_CLEAR) begin
            stb.clearErr = 1'b1;
          end
        end
      end
      ST_BUSY: begin
        if (opKind == OP_BLANK) begin
          if (!wordBlank) begin
            stb.setEraseErr = 1'b1;
            stateNext       = ST_IDLE;
          end else if (wordLast) begin
            stateNext = ST_IDLE;
          end else begin
            stb.wordStep = 1'b1;
          end
        end else if (pending && latZero) begin
          stb.dropPending = 1'b1;
          stateNext       = ST_PAUSED;
          if (opKind == OP_ERASE) stb.setSuspErase = 1'b1;
          else                    stb.setSuspProg  = 1'b1;
        end else begin
          if (verifyPass) begin
            finishOp = 1'b1;
          end else if (pulseLast) begin
            finishOp = 1'b1;
            if (opKind == OP_ERASE) stb.setEraseErr = 1'b1;
            else                    stb.setProgErr  = 1'b1;
          end else begin
            stb.pulseStep = 1'b1;
          end
          if (finishOp) begin
            stb.dropPending = 1'b1;
            stateNext       = ST_IDLE;
          end else if (pending) begin
            stb.stepLat = 1'b1;
          end else if (cmdValid && cmd == CMD_SUSPEND) begin
            stb.loadLat = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R6: a program or erase only launches with a valid supply
  a_r6_supply_at_start: assert property (@(posedge clk) disable iff (!rstN)
    (stb.startOp && opNext != OP_BLANK) |-> supplyOk);

  // R8: a program with a sticky fault stays refused
  a_r8_prog_refused: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cmdValid && cmd == CMD_PROGRAM && (errProg || errSupply))
      |=> (state == ST_IDLE));

  // R11: resume returns to busy with both suspend flags cleared
  a_r11_resume: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAUSED && cmdValid && cmd == CMD_RESUME)
      |=> (state == ST_BUSY && !suspErase && !suspProg));

  // R13: a suspend flag exists only while paused
  a_r13_susp_paused: assert property (@(posedge clk) disable iff (!rstN)
    (suspErase || suspProg) |-> (state == ST_PAUSED));

  // R12: no clear takes effect while busy
  a_r12_busy_no_clear: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.clearErr);

endmodule

// File: rtl/flash_status_ctl.sv
module flash_status_ctl
  import flash_ctl_pkg::*;
#(
  parameter int MAX_PULSES   = 8,
  parameter int SUSP_LATENCY = 4,
  parameter int BLOCK_WORDS  = 16,
  parameter int WORD_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdCode,
  input  logic              supplyOk,
  input  logic              verifyPass,
  input  logic [WORD_W-1:0] readWord,
  output logic [7:0]        status,
  output logic              busy
);

  strobe_t stb;
  logic wordBlank, pulseLast, wordLast, latZero, pending;
  logic errErase, errProg, errSupply, suspErase, suspProg;
  logic ready;

  flash_ctl_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmd        (cmd_e'(cmdCode)),
    .supplyOk   (supplyOk),
    .verifyPass (verifyPass),
    .wordBlank  (wordBlank),
    .pulseLast  (pulseLast),
    .wordLast   (wordLast),
    .latZero    (latZero),
    .pending    (pending),
    .errErase   (errErase),
    .errProg    (errProg),
    .errSupply  (errSupply),
    .suspErase  (suspErase),
    .suspProg   (suspProg),
    .stb        (stb),
    .busy       (busy)
  );

  flash_ctl_datapath #(
    .MAX_PULSES   (MAX_PULSES),
    .SUSP_LATENCY (SUSP_LATENCY),
    .BLOCK_WORDS  (BLOCK_WORDS),
    .WORD_W       (WORD_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .readWord   (readWord),
    .wordBlank  (wordBlank),
    .pulseLast  (pulseLast),
    .wordLast   (wordLast),
    .latZero    (latZero),
    .pending    (pending),
    .errErase   (errErase),
    .errProg    (errProg),
    .errSupply  (errSupply),
    .suspErase  (suspErase),
    .suspProg   (suspProg)
  );

  assign ready = !busy;

  always_comb begin
    status = '0;
    status[STAT_READY]     = ready;
    status[STAT_SUSP_ERS]  = ready & suspErase;
    status[STAT_ERASE_ERR] = errErase;
    status[STAT_PROG_ERR]  = errProg;
    status[STAT_SUPPLY]    = errSupply;
    status[STAT_SUSP_PRG]  = ready & suspProg;
  end

endmodule

// File: tb/flash_status_ctl_bench.sv
module flash_status_ctl_bench;

  localparam int MAXP = 6;
  localparam int LAT  = 3;
  localparam int BW   = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdCode = 3'd0;
  logic        supplyOk = 1'b1;
  logic        verifyPass = 1'b0;
  logic [15:0] readWord = 16'hFFFF;
  logic [7:0]  status;
  logic        busy;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_status_ctl #(
    .MAX_PULSES(MAXP), .SUSP_LATENCY(LAT), .BLOCK_WORDS(BW), .WORD_W(16)
  ) u_flash_status_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .supplyOk(supplyOk), .verifyPass(verifyPass), .readWord(readWord),
    .status(status), .busy(busy)
  );

  // Behavioural reference model: 0 idle, 1 busy, 2 paused
  int mSt = 0, mKind = 0, mPc = 0, mWc = 0, mLat = 0;
  bit mPend = 0, mEE = 0, mEP = 0, mEV = 0, mSE = 0, mSP = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mKind = 0; mPc = 0; mWc = 0; mLat = 0;
      mPend = 0; mEE = 0; mEP = 0; mEV = 0; mSE = 0; mSP = 0;
    end else if (mSt == 0) begin
      if (cmdValid) begin
        if (cmdCode == 3'd1 && !(mEP || mEV)) begin
          if (!supplyOk) mEV = 1; else begin mSt = 1; mKind = 1; mPc = 0; mWc = 0; end
        end else if (cmdCode == 3'd2 && !(mEE || mEV)) begin
          if (!supplyOk) mEV = 1; else begin mSt = 1; mKind = 2; mPc = 0; mWc = 0; end
        end else if (cmdCode == 3'd3 && !mEE) begin
          mSt = 1; mKind = 3; mPc = 0; mWc = 0;
        end else if (cmdCode == 3'd6) begin
          mEE = 0; mEP = 0; mEV = 0;
        end
      end
    end else if (mSt == 2) begin
      if (cmdValid && cmdCode == 3'd5) begin mSt = 1; mSE = 0; mSP = 0; end
      else if (cmdValid && cmdCode == 3'd6) begin mEE = 0; mEP = 0; mEV = 0; end
    end else begin
      if (mKind == 3) begin
        if (readWord != 16'hFFFF) begin mEE = 1; mSt = 0; end
        else if (mWc == BW - 1) mSt = 0;
        else mWc++;
      end else if (mPend && mLat == 0) begin
        mSt = 2; mPend = 0;
        if (mKind == 2) mSE = 1; else mSP = 1;
      end else begin
        bit fin;
        fin = 0;
        if (verifyPass) fin = 1;
        else if (mPc == MAXP - 1) begin
          fin = 1;
          if (mKind == 2) mEE = 1; else mEP = 1;
        end else mPc++;
        if (fin) begin mSt = 0; mPend = 0; end
        else if (mPend) mLat--;
        else if (cmdValid && cmdCode == 3'd4) begin mPend = 1; mLat = LAT - 1; end
      end
    end
  end

  function automatic logic [7:0] modelStatus();
    bit rdy;
    rdy = (mSt != 1);
    return {rdy, rdy & mSE, mEE, mEP, mEV, rdy & mSP, 2'b00};
  endfunction

  // Continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (status !== modelStatus() || busy !== (mSt == 1)) begin
        fails++;
        $display("FAIL model R2 status=%h busy=%b expected status=%h busy=%b",
                 status, busy, modelStatus(), (mSt == 1));
      end
    end
  end

  task automatic expectStat(input logic [7:0] exp, input string req);
    checks++;
    if (status !== exp || busy !== ~exp[7]) begin
      fails++;
      $display("FAIL %s status=%h busy=%b expected status=%h busy=%b",
               req, status, busy, exp, ~exp[7]);
    end
  endtask

  task automatic sendCmd(input logic [2:0] c);
    cmdValid = 1'b1;
    cmdCode  = c;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdCode  = 3'd0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    done = 1'b1;
    fails++;
    $display("FAIL watchdog R2 run did not finish: actual hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    expectStat(8'h80, "R1 reset");

    // R3: program passes on first pulse
    verifyPass = 1'b1;
    sendCmd(3'd1);
    expectStat(8'h00, "R2 busy during program");
    waitCycles(1);
    expectStat(8'h80, "R3 program done");

    // R14: program exhausts pulses
    verifyPass = 1'b0;
    sendCmd(3'd1);
    waitCycles(MAXP - 1);
    expectStat(8'h00, "R14 still pulsing");
    waitCycles(1);
    expectStat(8'h90, "R14 program error");
    sendCmd(3'd1);
    expectStat(8'h90, "R8 program refused");
    sendCmd(3'd6);
    expectStat(8'h80, "R7 clear");

    // R4: erase exhausts pulses
    sendCmd(3'd2);
    waitCycles(MAXP);
    expectStat(8'hA0, "R4 erase error");
    sendCmd(3'd2);
    expectStat(8'hA0, "R8 erase refused");
    sendCmd(3'd3);
    expectStat(8'hA0, "R8 blank refused");

    // R12: clear ignored during a program, errors stay sticky
    sendCmd(3'd1);
    sendCmd(3'd6);
    waitCycles(MAXP - 2);
    expectStat(8'h20, "R12 clear ignored while busy");
    waitCycles(1);
    expectStat(8'hB0, "R7 both errors held");
    sendCmd(3'd6);
    expectStat(8'h80, "R7 clear all");

    // R6: supply checked at start only
    supplyOk = 1'b0;
    sendCmd(3'd1);
    expectStat(8'h88, "R6 supply error");
    supplyOk = 1'b1;
    sendCmd(3'd2);
    expectStat(8'h88, "R8 erase refused on supply error");
    sendCmd(3'd6);
    sendCmd(3'd2);
    supplyOk = 1'b0;
    waitCycles(MAXP);
    expectStat(8'hA0, "R6 mid-op drop ignored");
    supplyOk = 1'b1;
    sendCmd(3'd6);

    // R5: blank check
    sendCmd(3'd3);
    waitCycles(BW - 1);
    expectStat(8'h00, "R5 blank scanning");
    waitCycles(1);
    expectStat(8'h80, "R5 blank clean");
    sendCmd(3'd3);
    readWord = 16'hFFEF;
    waitCycles(1);
    expectStat(8'hA0, "R5 blank mismatch");
    readWord = 16'hFFFF;
    sendCmd(3'd6);

    // R9/R11: erase suspend and resume
    sendCmd(3'd2);
    sendCmd(3'd4);
    waitCycles(LAT - 1);
    expectStat(8'h00, "R13 no suspend bit while busy");
    waitCycles(1);
    expectStat(8'hC0, "R9 erase paused");
    sendCmd(3'd1);
    expectStat(8'hC0, "R12 program ignored while paused");
    sendCmd(3'd5);
    expectStat(8'h00, "R11 resumed");
    waitCycles(MAXP - LAT - 1);
    expectStat(8'h00, "R11 remaining pulses");
    waitCycles(1);
    expectStat(8'hA0, "R11 count kept");
    sendCmd(3'd6);

    // R9: program suspend
    sendCmd(3'd1);
    sendCmd(3'd4);
    waitCycles(LAT);
    expectStat(8'h84, "R9 program paused");
    verifyPass = 1'b1;
    sendCmd(3'd5);
    expectStat(8'h00, "R11 program resumed");
    waitCycles(1);
    expectStat(8'h80, "R11 program finished");

    // R10: completion inside latency window
    verifyPass = 1'b0;
    sendCmd(3'd1);
    sendCmd(3'd4);
    verifyPass = 1'b1;
    waitCycles(1);
    expectStat(8'h80, "R10 completed in window");
    waitCycles(LAT + 1);
    expectStat(8'h80, "R10 no suspend bit");
    verifyPass = 1'b0;

    // R12: stray suspend/resume
    sendCmd(3'd4);
    sendCmd(3'd5);
    expectStat(8'h80, "R12 idle suspend/resume ignored");
    sendCmd(3'd3);
    sendCmd(3'd4);
    waitCycles(BW - 2);
    expectStat(8'h00, "R12 blank not suspended");
    waitCycles(1);
    expectStat(8'h80, "R12 blank complete");

    waitCycles(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule